// File: doc/BRIEF.md
# Locality-Class Adaptive Bypass Controller

This block sits beside an L1 data cache and tells each incoming load request whether it should be allocated in the cache or sent around it. Every static load arrives with a two-bit locality class assigned earlier by profiling. Two of the classes have a fixed answer: loads judged to reuse their lines well are always cached, and loads judged to reuse them badly always skip the L1. Loads in the middle class are steered as a group, one decision per thread block: a block whose identifier is below a running threshold caches them, any other block bypasses them.

The threshold adapts by itself. The block counts single-cycle L1 hit pulses and pipeline resource conflict pulses over a fixed window of cycles. When a window closes, the threshold steps up by one if hits outnumbered conflicts during that window, and down by one otherwise, staying inside the range from zero to the number of thread blocks that can be resident at once. The decision is combinational on the request fields and the registered threshold, so it is ready in the cycle the request is presented.

Top module: `lcab_top`

## Requirements
- R1: A request with class code 2'b00 (good locality) gets bypass = 0 in the same cycle, whatever its block ID and the threshold.
- R2: A request with class code 2'b01 (poor locality) gets bypass = 1 in the same cycle.
- R3: A request with class code 2'b10 (moderate locality) gets bypass = 0 when its block ID is strictly below the current threshold and bypass = 1 otherwise, in the same cycle.
- R4: The unused class code 2'b11 is treated as bypass = 1.
- R5: While rst_n is low at a clock edge, the threshold is loaded with INIT_THRESH (default 8) and the cycle and event counts are cleared.
- R6: The threshold changes only at the clock edge that closes a window; the first window closes at the WINDOW-th rising edge (default 1024) with rst_n high, and each later one WINDOW edges after the previous.
- R7: When a window closes with more hit pulses than conflict pulses, the threshold rises by one; pulses sampled at every edge of the window count, the closing edge included.
- R8: When a window closes with conflict pulses equal to or greater than hit pulses, the threshold falls by one.
- R9: The threshold never goes below 0 nor above MAX_RESIDENT (default 16); at a limit a step that would leave the range is dropped.
- R10: Hit and conflict counts restart from zero for each new window; pulses in one window have no effect on the decision taken at the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_class | input | 2 | Locality class of the current load: 00 good, 01 poor, 10 moderate, 11 unused |
| req_tb_id | input | $clog2(MAX_RESIDENT) | Thread-block identifier of the current load |
| l1_hit | input | 1 | One pulse per L1 hit observed this cycle |
| res_conflict | input | 1 | One pulse per pipeline resource conflict observed this cycle |
| bypass | output | 1 | 1 = send the load around the L1, 0 = cache it |

## Verification
The hardest situations to reach are the window boundary cases: a window in which hits beat conflicts only because of a pulse on its very last cycle, a window that ends in an exact tie, and steps taken while the threshold sits at either end of its range. The stimulus tracks the reference model's cycle position, so it can drive equal hit and conflict pulses for a whole window and add one lone hit on the closing edge, and it runs long biased phases that push the threshold into both clamps and hold it there. Moderate requests are aimed at block IDs equal to and one below the expected threshold, so that every single step of the threshold shows up at the bypass output.

// File: rtl/lcab_pkg.sv
// Shared definitions for the locality-class adaptive bypass controller.
// Assumes the class code is a two-bit field supplied with every request.
package lcab_pkg;

    // Locality class codes carried by each static load
    typedef enum logic [1:0] {
        LC_GOOD = 2'b00,
        LC_POOR = 2'b01,
        LC_MOD  = 2'b10,
        LC_RSVD = 2'b11
    } loc_class_e;

    // Index of each event channel in the window counter
    localparam int EV_HIT  = 0;
    localparam int EV_CONF = 1;
    localparam int EV_NUM  = 2;

endpackage

// File: rtl/lcab_window.sv
// Window timer and event counters.
// Counts a fixed number of cycles per window and, for each event channel,
// the number of pulses in the window. The totals it outputs already include
// the pulses of the current cycle, so on the closing cycle they cover the
// whole window. Assumes each channel delivers at most one pulse per cycle.
module lcab_window #(
    parameter int WINDOW = 1024,
    parameter int NCH    = 2,
    localparam int CYC_W = (WINDOW > 1) ? $clog2(WINDOW) : 1,
    localparam int CNT_W = $clog2(WINDOW + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NCH-1:0]             ev_i,
    output logic                       win_end_o,
    output logic [NCH-1:0][CNT_W-1:0]  tot_o
);

    localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(WINDOW - 1);

    logic [CYC_W-1:0] cyc_q;

    // Closing cycle of the current window
    assign win_end_o = (cyc_q == LAST_CYC);

    // Cycle position inside the window, wraps at the closing cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (win_end_o) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // One pulse counter per event channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [CNT_W-1:0] cnt_q;

        // Running total including the pulse of this cycle
        assign tot_o[ch] = cnt_q + CNT_W'(ev_i[ch]);

        // Accumulate pulses, restart at each window boundary
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (win_end_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= tot_o[ch];
            end
        end
    end

endmodule

// File: rtl/lcab_thresh.sv
// Adaptive threshold register.
// At each window close, steps the threshold up by one when hits exceeded
// conflicts and down by one otherwise (ties go down), holding it inside
// 0..MAX_RESIDENT. Assumes INIT_THRESH lies inside that range.
module lcab_thresh #(
    parameter int MAX_RESIDENT = 16,
    parameter int INIT_THRESH  = 8,
    parameter int CNT_W        = 11,
    localparam int TH_W        = $clog2(MAX_RESIDENT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_end_i,
    input  logic [CNT_W-1:0] hit_tot_i,
    input  logic [CNT_W-1:0] conf_tot_i,
    output logic [TH_W-1:0]  thresh_o
);

    localparam logic [TH_W-1:0] TH_MAX  = TH_W'(MAX_RESIDENT);
    localparam logic [TH_W-1:0] TH_INIT = TH_W'(INIT_THRESH);

    logic            hits_win;
    logic [TH_W-1:0] th_next;

    // Direction of the step for this window
    assign hits_win = (hit_tot_i > conf_tot_i);

    // Next threshold value with clamping at both ends
    always_comb begin
        th_next = thresh_o;
        if (hits_win) begin
            if (thresh_o != TH_MAX) th_next = thresh_o + 1'b1;
        end else begin
            if (thresh_o != '0) th_next = thresh_o - 1'b1;
        end
    end

    // Threshold register, updated only at window close
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thresh_o <= TH_INIT;
        end else if (win_end_i) begin
            thresh_o <= th_next;
        end
    end

endmodule

// File: rtl/lcab_decide.sv
// Cache/bypass decision.
// Purely combinational: good loads cache, poor and unused-code loads
// bypass, moderate loads cache only when the block ID is below threshold.
module lcab_decide #(
    parameter int TB_W = 4,
    parameter int TH_W = 5
) (
    input  logic [1:0]      class_i,
    input  logic [TB_W-1:0] tb_id_i,
    input  logic [TH_W-1:0] thresh_i,
    output logic            bypass_o
);
    import lcab_pkg::*;

    logic below;

    // Block ID widened to threshold width for comparison
    assign below = (TH_W'(tb_id_i) < thresh_i);

    // Select by locality class
    always_comb begin
        case (loc_class_e'(class_i))
            LC_GOOD: bypass_o = 1'b0;
            LC_POOR: bypass_o = 1'b1;
            LC_MOD:  bypass_o = ~below;
            default: bypass_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/lcab_top.sv
// Locality-class adaptive bypass controller, top level.
// Connects the window counters, the threshold register and the decision
// logic. Assumes MAX_RESIDENT >= 2, WINDOW >= 2, l1_hit and res_conflict
// are single-cycle pulses, and reset is held for at least one edge.
module lcab_top #(
    parameter int MAX_RESIDENT = 16,
    parameter int WINDOW       = 1024,
    parameter int INIT_THRESH  = 8,
    localparam int TB_W        = $clog2(MAX_RESIDENT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      req_class,
    input  logic [TB_W-1:0] req_tb_id,
    input  logic            l1_hit,
    input  logic            res_conflict,
    output logic            bypass
);
    import lcab_pkg::*;

    localparam int TH_W  = $clog2(MAX_RESIDENT + 1);
    localparam int CNT_W = $clog2(WINDOW + 1);

    logic [EV_NUM-1:0]             ev;
    logic                          win_end;
    logic [EV_NUM-1:0][CNT_W-1:0]  tot;
    logic [TH_W-1:0]               thresh;

    // Gather event pulses into channel order
    always_comb begin
        ev          = '0;
        ev[EV_HIT]  = l1_hit;
        ev[EV_CONF] = res_conflict;
    end

    lcab_window #(
        .WINDOW (WINDOW),
        .NCH    (EV_NUM)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev),
        .win_end_o (win_end),
        .tot_o     (tot)
    );

    lcab_thresh #(
        .MAX_RESIDENT (MAX_RESIDENT),
        .INIT_THRESH  (INIT_THRESH),
        .CNT_W        (CNT_W)
    ) u_th (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_end_i  (win_end),
        .hit_tot_i  (tot[EV_HIT]),
        .conf_tot_i (tot[EV_CONF]),
        .thresh_o   (thresh)
    );

    lcab_decide #(
        .TB_W (TB_W),
        .TH_W (TH_W)
    ) u_dec (
        .class_i  (req_class),
        .tb_id_i  (req_tb_id),
        .thresh_i (thresh),
        .bypass_o (bypass)
    );

endmodule

// File: rtl/lcab_chk.sv
// Assertion checker for lcab_top, attached with bind below.
// Observes the request ports, the decision and the internal threshold.
module lcab_chk #(
    parameter int MAX_RESIDENT = 16,
    parameter int TB_W         = 4,
    parameter int TH_W         = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      req_class,
    input logic [TB_W-1:0] req_tb_id,
    input logic            bypass,
    input logic [TH_W-1:0] thresh,
    input logic            win_end
);

    localparam logic [TH_W-1:0] TH_MAX = TH_W'(MAX_RESIDENT);

    a_r1_good_caches: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == 2'b00) |-> !bypass);

    a_r2_poor_bypasses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == 2'b01) |-> bypass);

    a_r4_unused_bypasses: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == 2'b11) |-> bypass);

    a_r3_moderate_split: assert property (@(posedge clk) disable iff (!rst_n)
        (req_class == 2'b10) |-> (bypass == (TH_W'(req_tb_id) >= thresh)));

    a_r6_hold_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(thresh));

    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> ((thresh == $past(thresh) + TH_W'(1)) ||
                     (thresh + TH_W'(1) == $past(thresh)) ||
                     (thresh == $past(thresh))));

    a_r9_upper_bound: assert property (@(posedge clk) disable iff (!rst_n)
        thresh <= TH_MAX);

    a_r9_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh == '0) |=> (thresh <= TH_W'(1)));

endmodule

bind lcab_top lcab_chk #(
    .MAX_RESIDENT (MAX_RESIDENT),
    .TB_W         (TB_W),
    .TH_W         (TH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_class (req_class),
    .req_tb_id (req_tb_id),
    .bypass    (bypass),
    .thresh    (thresh),
    .win_end   (win_end)
);

// File: tb/sim_lcab_top.sv
// Bench for lcab_top: behavioural reference model compared every cycle.
module sim_lcab_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAXR       = 16;
    localparam int WIN        = 1024;
    localparam int INIT_TH    = 8;
    localparam int TBW        = $clog2(MAXR);
    localparam int WATCHDOG   = 150000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     req_class = 2'b00;
    logic [TBW-1:0] req_tb_id = '0;
    logic           l1_hit = 1'b0;
    logic           res_conflict = 1'b0;
    logic           bypass;

    int total = 0;
    int bad   = 0;
    int ncyc  = 0;

    // reference model state
    int    m_th   = INIT_TH;
    int    m_cyc  = 0;
    int    m_hits = 0;
    int    m_conf = 0;
    string m_last = "none";

    lcab_top #(
        .MAX_RESIDENT (MAXR),
        .WINDOW       (WIN),
        .INIT_THRESH  (INIT_TH)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_class    (req_class),
        .req_tb_id    (req_tb_id),
        .l1_hit       (l1_hit),
        .res_conflict (res_conflict),
        .bypass       (bypass)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model: window counting and threshold stepping
    always @(posedge clk) begin
        ncyc <= ncyc + 1;
        if (!rst_n) begin
            m_th   = INIT_TH;
            m_cyc  = 0;
            m_hits = 0;
            m_conf = 0;
        end else begin
            m_hits = m_hits + int'(l1_hit);
            m_conf = m_conf + int'(res_conflict);
            if (m_cyc == WIN - 1) begin
                if (m_hits > m_conf) begin
                    if (m_th < MAXR) begin m_th = m_th + 1; m_last = "R7 up"; end
                    else m_last = "R9 clamp high";
                end else begin
                    if (m_th > 0) begin m_th = m_th - 1; m_last = "R8 down"; end
                    else m_last = "R9 clamp low";
                end
                m_hits = 0;
                m_conf = 0;
                m_cyc  = 0;
            end else begin
                m_cyc = m_cyc + 1;
            end
        end
    end

    function automatic logic exp_byp(input logic [1:0] c, input int id, input int th);
        case (c)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return (id >= th);
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: bypass=%0b expected=%0b (class=%0b id=%0d model_th=%0d)",
                     tag, act, exp, req_class, req_tb_id, m_th);
        end
    endtask

    // compare current request against the model
    task automatic cmp_now();
        string tag;
        case (req_class)
            2'b00:   tag = "R1 good";
            2'b01:   tag = "R2 poor";
            2'b10:   tag = $sformatf("R3 moderate, R6 R10 window, last step %s", m_last);
            default: tag = "R4 unused code";
        endcase
        check(tag, bypass, exp_byp(req_class, int'(req_tb_id), m_th));
    endtask

    // random request aimed near the threshold for moderate loads
    task automatic pick_req();
        int sel;
        int id;
        req_class = 2'($urandom_range(3, 0));
        if (req_class == 2'b11 && $urandom_range(3, 0) != 0) req_class = 2'b10;
        sel = $urandom_range(3, 0);
        if (sel == 0)      id = m_th;
        else if (sel == 1) id = m_th - 1;
        else               id = $urandom_range(MAXR - 1, 0);
        if (id < 0) id = 0;
        if (id > MAXR - 1) id = MAXR - 1;
        req_tb_id = TBW'(id);
    endtask

    // mode: 0 hits dominate, 1 exact tie, 2 conflicts dominate,
    //       3 near-even random, 4 tie plus one hit on the closing cycle
    task automatic run_cycles(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pick_req();
            case (mode)
                0: begin l1_hit = ($urandom_range(1, 0) == 1); res_conflict = ($urandom_range(7, 0) == 0); end
                1: begin l1_hit = ($urandom_range(1, 0) == 1); res_conflict = l1_hit; end
                2: begin res_conflict = ($urandom_range(1, 0) == 1); l1_hit = ($urandom_range(7, 0) == 0); end
                3: begin l1_hit = ($urandom_range(1, 0) == 1); res_conflict = ($urandom_range(1, 0) == 1); end
                default: begin
                    if (m_cyc == WIN - 1) begin l1_hit = 1'b1; res_conflict = 1'b0; end
                    else begin l1_hit = ($urandom_range(1, 0) == 1); res_conflict = l1_hit; end
                end
            endcase
            #1;
            cmp_now();
        end
    endtask

    // watchdog: an expired run counts as a failed check
    always @(posedge clk) begin
        if (ncyc > WATCHDOG) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", ncyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // reset state, R5: threshold starts at INIT_TH
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        req_class = 2'b10; req_tb_id = TBW'(INIT_TH - 1); #1;
        check("R5 reset threshold, id just below", bypass, 1'b0);
        @(negedge clk);
        req_tb_id = TBW'(INIT_TH); #1;
        check("R5 reset threshold, id at threshold", bypass, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: no change before the first window closes, even with many hits
        run_cycles(WIN - 10, 0);
        @(negedge clk);
        req_class = 2'b10; req_tb_id = TBW'(INIT_TH); l1_hit = 1'b1; #1;
        check("R6 threshold unchanged mid window", bypass, 1'b1);

        // R7 then R9: climb to the upper clamp and stay there
        run_cycles(WIN * 11, 0);
        // R8: exact ties step down
        run_cycles(WIN * 3, 1);
        // R7: tie broken only by a hit on the closing cycle
        run_cycles(WIN * 2, 4);
        // R8 then R9: fall to the lower clamp and stay there
        run_cycles(WIN * 20, 2);
        // R10: leave the low clamp with fresh windows
        run_cycles(WIN * 3, 0);
        // mixed traffic around a tie
        run_cycles(WIN * 6, 3);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule